// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects thirty-two level-sensitive interrupt request lines from around the chip. It qualifies them with a per-source enable mask and raises a single `irq` line toward the processor. A set of prioritised vector slots maps source numbers to handler addresses. Each slot is given one source number, an enable bit and a handler address. Slot 0 has the highest priority. When the processor reads the vector register, it receives the handler address of the winning slot. If an enabled request is pending but no enabled slot claims it, the read returns a programmable default address.

The vector read also enters the winning priority level into an in-service record. From then on, only levels of strictly higher priority can raise `irq` and win a later read, which gives nested preemption. A write of any value to the vector register (by convention zero) ends the most recently entered level, which is always the highest one in service.

Software uses a small word-addressed register bus with a single-cycle write and a combinational read. The word map is:

- 0: enable set. Writing a one sets that source bit; reading returns the mask.
- 1: enable clear. Writing a one clears that source bit.
- 2: vector. A read returns the winner; a write acknowledges.
- 3: default handler address.
- 16+n: control word of slot n.
- 32+n: handler address of slot n.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Reset clears the enable mask, every slot control word and the in-service record. After reset, `irq` is low for any request pattern, and a request that is enabled afterwards is not blocked by service that was in progress before the reset.
- R2: A write to word 0 ORs the write data into the enable mask, where bit k enables source k. Zero bits in the write data leave mask bits unchanged. A read of word 0 or word 1 returns the mask.
- R3: A write to word 1 clears every mask bit whose write-data bit is one and leaves the other mask bits unchanged.
- R4: While no level is in service, `irq` equals the OR over all sources of (request AND enable bit). A pending source that is not enabled has no effect.
- R5: The slot control word at word 16+n holds the slot enable in bit 5 and the served source number in bits 4:0, and it reads back as written. The handler address at word 32+n also reads back as written.
- R6: A read of word 2 returns the handler address of the lowest-numbered enabled slot whose source is both pending and enabled, including the last slot.
- R7: If an enabled request is pending but no enabled slot serves its source, and no slot wins, `irq` is high and a vector read returns the default address held in word 3.
- R8: A vector read that returns a winner enters that level into service. From then on, only slots with a lower index can raise `irq` or win. The default level is the lowest priority and can be preempted by any slot.
- R9: A write to word 2 ends the highest-priority level in service, which lets that level and lower levels request again. A write with nothing in service has no effect.
- R10: A slot whose control bit 5 is zero is ignored. A request on its source is then routed to the default address, and after the slot is enabled the same request returns the slot's address.
- R11: A vector read while `irq` is low returns the default address and leaves the in-service record unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_src | input | 32 | Interrupt request lines, bit k is source k, level sensitive |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq | output | 1 | Interrupt to the processor |

## Verification
`irq` and the read data are combinational from the requests and the registered state, so both are due in the same cycle as the stimulus. Mask, slot and in-service updates from a write or a vector read appear from the following cycle on. The bench drives every access at the falling edge, compares `irq` and the read data shortly afterwards, before the rising edge commits the access, and only then moves to the next access. As a result, each check sees exactly the state left by all earlier accesses. After the external reset is released, the bench waits out the two-cycle synchronizer before it issues the first access.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int NUM_SRC = 32;
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int DATA_W  = 32;
  localparam int BUS_AW  = 6;
  localparam int CTRL_EN_BIT = SRC_W;          // slot enable sits above the source field

  localparam logic [BUS_AW-1:0] A_EN_SET    = 6'd0;
  localparam logic [BUS_AW-1:0] A_EN_CLR    = 6'd1;
  localparam logic [BUS_AW-1:0] A_VECTOR    = 6'd2;
  localparam logic [BUS_AW-1:0] A_DEFAULT   = 6'd3;
  localparam int                CTRL_BASE   = 16;
  localparam int                HADDR_BASE  = 32;
  localparam int                MAX_SLOTS   = 16;
endpackage

// File: rtl/vec_irq_regs.sv
module vec_irq_regs
  import vec_irq_pkg::*;
#(
  parameter int NSLOT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_SRC-1:0] en_mask,
  output logic [DATA_W-1:0] def_addr,
  output logic [NSLOT-1:0]  slot_en,
  output logic [SRC_W-1:0]  slot_src  [NSLOT],
  output logic [DATA_W-1:0] slot_addr [NSLOT]
);
  logic [NUM_SRC-1:0] mask_nxt;
  logic               def_we;

  always_comb begin
    mask_nxt = en_mask;
    if (wr_en && addr == A_EN_SET)      mask_nxt = en_mask | wdata;
    else if (wr_en && addr == A_EN_CLR) mask_nxt = en_mask & ~wdata;
  end

  assign def_we = wr_en && (addr == A_DEFAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_mask <= '0;
    else        en_mask <= mask_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      def_addr <= '0;
    else if (def_we) def_addr <= wdata;
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [BUS_AW-1:0] CA = BUS_AW'(CTRL_BASE + i);
    localparam logic [BUS_AW-1:0] HA = BUS_AW'(HADDR_BASE + i);
    logic ctrl_we, addr_we;
    assign ctrl_we = wr_en && (addr == CA);
    assign addr_we = wr_en && (addr == HA);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_en[i]  <= 1'b0;
        slot_src[i] <= '0;
      end else if (ctrl_we) begin
        slot_en[i]  <= wdata[CTRL_EN_BIT];
        slot_src[i] <= wdata[SRC_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_addr[i] <= '0;
      else if (addr_we) slot_addr[i] <= wdata;
    end
  end
endmodule

// File: rtl/vec_irq_arb.sv
module vec_irq_arb
  import vec_irq_pkg::*;
#(
  parameter int NSLOT = 16
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [NSLOT-1:0]   slot_en,
  input  logic [SRC_W-1:0]   slot_src  [NSLOT],
  input  logic [DATA_W-1:0]  slot_addr [NSLOT],
  input  logic [DATA_W-1:0]  def_addr,
  input  logic [NSLOT:0]     svc,
  output logic [NSLOT:0]     win_1h,
  output logic               win_any,
  output logic [DATA_W-1:0]  win_addr
);
  logic [NSLOT-1:0]   hit;
  logic [NUM_SRC-1:0] claimed;

  for (genvar i = 0; i < NSLOT; i++) begin : g_hit
    assign hit[i] = slot_en[i] & req[slot_src[i]];
  end

  always_comb begin
    claimed = '0;
    for (int i = 0; i < NSLOT; i++)
      if (slot_en[i]) claimed[slot_src[i]] = 1'b1;
  end

  // Walk from highest priority down; a level is blocked once any level at or above it is in service.
  always_comb begin
    logic blocked, taken, cand;
    blocked = 1'b0;
    taken   = 1'b0;
    win_1h  = '0;
    for (int i = 0; i < NSLOT; i++) begin
      blocked   = blocked | svc[i];
      cand      = hit[i] & ~blocked;
      win_1h[i] = cand & ~taken;
      taken     = taken | cand;
    end
    blocked       = blocked | svc[NSLOT];
    win_1h[NSLOT] = (|(req & ~claimed)) & ~blocked & ~taken;
  end

  assign win_any = |win_1h;

  always_comb begin
    win_addr = def_addr;
    for (int i = 0; i < NSLOT; i++)
      if (win_1h[i]) win_addr = slot_addr[i];
  end
endmodule

// File: rtl/vec_irq_svc.sv
module vec_irq_svc #(
  parameter int NSLOT = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [NSLOT:0] win_1h,
  input  logic           ack,
  output logic [NSLOT:0] svc
);
  localparam logic [NSLOT:0] ONE = {{NSLOT{1'b0}}, 1'b1};
  logic [NSLOT:0] svc_nxt;

  // Lowest index = highest priority, so acknowledge drops the least significant set bit.
  always_comb begin
    svc_nxt = svc;
    if (take)     svc_nxt = svc | win_1h;
    else if (ack) svc_nxt = svc & (svc - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc <= '0;
    else        svc <= svc_nxt;
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int NSLOT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic               rst_m, rst_q;
  logic               wr_en, rd_en, vec_rd, vec_ack;
  logic [NUM_SRC-1:0] en_mask, req;
  logic [DATA_W-1:0]  def_addr, win_addr;
  logic [NSLOT-1:0]   slot_en;
  logic [SRC_W-1:0]   slot_src  [NSLOT];
  logic [DATA_W-1:0]  slot_addr [NSLOT];
  logic [NSLOT:0]     win_1h, svc_state;
  logic               win_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;
  assign vec_rd  = rd_en & (bus_addr == A_VECTOR);
  assign vec_ack = wr_en & (bus_addr == A_VECTOR);
  assign req     = irq_src & en_mask;

  vec_irq_regs #(.NSLOT(NSLOT)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
    .en_mask(en_mask), .def_addr(def_addr), .slot_en(slot_en),
    .slot_src(slot_src), .slot_addr(slot_addr)
  );

  vec_irq_arb #(.NSLOT(NSLOT)) u_arb (
    .req(req), .slot_en(slot_en), .slot_src(slot_src), .slot_addr(slot_addr),
    .def_addr(def_addr), .svc(svc_state), .win_1h(win_1h), .win_any(win_any),
    .win_addr(win_addr)
  );

  vec_irq_svc #(.NSLOT(NSLOT)) u_svc (
    .clk(clk), .rst_n(rst_q), .take(vec_rd), .win_1h(win_1h), .ack(vec_ack),
    .svc(svc_state)
  );

  assign irq = win_any;

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (bus_addr == A_EN_SET || bus_addr == A_EN_CLR) bus_rdata = en_mask;
      else if (bus_addr == A_VECTOR)                    bus_rdata = win_addr;
      else if (bus_addr == A_DEFAULT)                   bus_rdata = def_addr;
      for (int i = 0; i < NSLOT; i++) begin
        if (bus_addr == BUS_AW'(CTRL_BASE + i))
          bus_rdata = DATA_W'({slot_en[i], slot_src[i]});
        if (bus_addr == BUS_AW'(HADDR_BASE + i))
          bus_rdata = slot_addr[i];
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk
  import vec_irq_pkg::*;
#(
  parameter int NSLOT = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NUM_SRC-1:0] irq_src,
  input logic              irq,
  input logic [NUM_SRC-1:0] en_mask,
  input logic [NSLOT:0]    svc
);
  logic clr_wr, vec_rd, vec_wr;
  assign clr_wr = bus_sel && bus_wr && bus_addr == A_EN_CLR;
  assign vec_rd = bus_sel && !bus_wr && bus_addr == A_VECTOR;
  assign vec_wr = bus_sel && bus_wr && bus_addr == A_VECTOR;

  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((en_mask & $past(en_mask)) == $past(en_mask))); // R2

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((en_mask & $past(bus_wdata)) == '0)); // R3

  AST_IDLE_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (svc == '0) |-> (irq == |(irq_src & en_mask))); // R4

  AST_READ_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && irq) |=> ($countones(svc) == $past($countones(svc)) + 1)); // R8

  AST_ACK_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_wr && svc != '0) |=> ($countones(svc) + 1 == $past($countones(svc)))); // R9

  AST_IDLE_READ_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !irq) |=> $stable(svc)); // R11
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_q), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_src(irq_src), .irq(irq), .en_mask(en_mask), .svc(svc_state)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  vec_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  typedef struct packed {
    logic        wr;
    logic [5:0]  a;
    logic [31:0] d;
    logic [31:0] s;
    logic        chk;
    logic [31:0] exp;
    logic        eirq;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 6'd3,  32'hDEF00000, 32'h0,        1'b0, 32'h0,        1'b0, 4'd1},  // R1 irq low after reset
    '{1'b0, 6'd0,  32'h0,        32'h0,        1'b1, 32'h0,        1'b0, 4'd1},  // R1 mask clear
    '{1'b1, 6'd16, 32'h24,       32'h0,        1'b0, 32'h0,        1'b0, 4'd5},  // slot0: src4
    '{1'b1, 6'd32, 32'h1000,     32'h0,        1'b0, 32'h0,        1'b0, 4'd5},
    '{1'b1, 6'd17, 32'h31,       32'h0,        1'b0, 32'h0,        1'b0, 4'd5},  // slot1: src17
    '{1'b1, 6'd33, 32'h2000,     32'h0,        1'b0, 32'h0,        1'b0, 4'd5},
    '{1'b1, 6'd18, 32'h06,       32'h0,        1'b0, 32'h0,        1'b0, 4'd5},  // slot2 disabled: src6
    '{1'b1, 6'd34, 32'h3000,     32'h0,        1'b0, 32'h0,        1'b0, 4'd5},
    '{1'b1, 6'd0,  32'h00020010, 32'h0,        1'b0, 32'h0,        1'b0, 4'd2},
    '{1'b0, 6'd0,  32'h0,        32'h0,        1'b1, 32'h00020010, 1'b0, 4'd2},  // R2
    '{1'b1, 6'd0,  32'h00000040, 32'h0,        1'b0, 32'h0,        1'b0, 4'd2},
    '{1'b0, 6'd0,  32'h0,        32'h0,        1'b1, 32'h00020050, 1'b0, 4'd2},  // R2 OR update
    '{1'b0, 6'd17, 32'h0,        32'h0,        1'b1, 32'h31,       1'b0, 4'd5},  // R5
    '{1'b0, 6'd34, 32'h0,        32'h0,        1'b1, 32'h3000,     1'b0, 4'd5},  // R5
    '{1'b0, 6'd2,  32'h0,        32'h00020000, 1'b1, 32'h2000,     1'b1, 4'd6},  // R6 slot1 wins
    '{1'b0, 6'd2,  32'h0,        32'h00020010, 1'b1, 32'h1000,     1'b1, 4'd8},  // R8 slot0 preempts
    '{1'b1, 6'd2,  32'h0,        32'h00020010, 1'b0, 32'h0,        1'b0, 4'd8},  // R8 all blocked
    '{1'b0, 6'd0,  32'h0,        32'h00000010, 1'b1, 32'h00020050, 1'b1, 4'd8},  // R8 slot0 over slot1
    '{1'b0, 6'd0,  32'h0,        32'h00020000, 1'b1, 32'h00020050, 1'b0, 4'd8},  // R8 same level held
    '{1'b1, 6'd2,  32'h0,        32'h00020000, 1'b0, 32'h0,        1'b0, 4'd9},
    '{1'b0, 6'd0,  32'h0,        32'h00020000, 1'b1, 32'h00020050, 1'b1, 4'd9},  // R9 released
    '{1'b1, 6'd2,  32'h0,        32'h0,        1'b0, 32'h0,        1'b0, 4'd9},  // R9 idle ack
    '{1'b0, 6'd2,  32'h0,        32'h00000040, 1'b1, 32'hDEF00000, 1'b1, 4'd7},  // R7 default
    '{1'b0, 6'd2,  32'h0,        32'h00020040, 1'b1, 32'h2000,     1'b1, 4'd8},  // R8 preempt default
    '{1'b1, 6'd2,  32'h0,        32'h0,        1'b0, 32'h0,        1'b0, 4'd9},
    '{1'b1, 6'd2,  32'h0,        32'h0,        1'b0, 32'h0,        1'b0, 4'd9},
    '{1'b0, 6'd2,  32'h0,        32'h0,        1'b1, 32'hDEF00000, 1'b0, 4'd11}, // R11 idle read
    '{1'b0, 6'd0,  32'h0,        32'h00000010, 1'b1, 32'h00020050, 1'b1, 4'd11}, // R11 nothing entered
    '{1'b1, 6'd1,  32'h00000010, 32'h00000010, 1'b0, 32'h0,        1'b1, 4'd3},
    '{1'b0, 6'd0,  32'h0,        32'h00000010, 1'b1, 32'h00020040, 1'b0, 4'd3},  // R3
    '{1'b0, 6'd0,  32'h0,        32'h00000020, 1'b1, 32'h00020040, 1'b0, 4'd4},  // R4 not enabled
    '{1'b0, 6'd0,  32'h0,        32'h00020040, 1'b1, 32'h00020040, 1'b1, 4'd4}   // R4 OR
  };

  task automatic check(input int rq, input string what, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL R%0d %s: got %08h expected %08h", rq, what, got, exp);
    end
  endtask

  task automatic op(input logic wr, input logic [5:0] a, input logic [31:0] d, input logic [31:0] s,
                    input logic chk, input logic [31:0] exp, input logic eirq, input int rq);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; irq_src = s;
    #2;
    check(rq, "irq", {31'b0, irq}, {31'b0, eirq});
    if (chk) check(rq, "rdata", bus_rdata, exp);
    @(posedge clk);
  endtask

  task automatic idle;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    for (int i = 0; i < NV; i++)
      op(TBL[i].wr, TBL[i].a, TBL[i].d, TBL[i].s, TBL[i].chk, TBL[i].exp, TBL[i].eirq, int'(TBL[i].rq));

    // R10: disabled slot2 sends src6 to default; enabling it returns its own address
    op(1'b0, 6'd2, 32'h0, 32'h40, 1'b1, 32'hDEF00000, 1'b1, 10);
    op(1'b1, 6'd2, 32'h0, 32'h40, 1'b0, 32'h0, 1'b0, 10);
    op(1'b1, 6'd18, 32'h26, 32'h40, 1'b0, 32'h0, 1'b1, 10);
    op(1'b0, 6'd2, 32'h0, 32'h40, 1'b1, 32'h3000, 1'b1, 10);
    op(1'b1, 6'd2, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, 10);

    // R6 boundary: last slot serving the top source
    op(1'b1, 6'd31, 32'h3F, 32'h0, 1'b0, 32'h0, 1'b0, 6);
    op(1'b1, 6'd47, 32'hF000, 32'h0, 1'b0, 32'h0, 1'b0, 6);
    op(1'b1, 6'd0, 32'h80000000, 32'h0, 1'b0, 32'h0, 1'b0, 6);
    op(1'b0, 6'd2, 32'h0, 32'h80000000, 1'b1, 32'hF000, 1'b1, 6);  // slot15 enters service

    // R1: reset in the middle of service
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    op(1'b0, 6'd0, 32'h0, 32'hFFFFFFFF, 1'b1, 32'h0, 1'b0, 1);
    op(1'b0, 6'd31, 32'h0, 32'h80000000, 1'b1, 32'h0, 1'b0, 1);
    op(1'b1, 6'd0, 32'h80000000, 32'h80000000, 1'b0, 32'h0, 1'b0, 1);
    op(1'b0, 6'd0, 32'h0, 32'h80000000, 1'b1, 32'h80000000, 1'b1, 1);  // service cleared
    idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule